// File: doc/BRIEF.md
# Two-Key Register Write-Protection Gate

This block stands between a register bus and a peripheral register file, and decides which writes the file may take. Protected registers accept a write only while the gate is open. The gate opens after a short unlock sequence. Software writes a fixed 32-bit key to the first kick address, and then a second, different key to the second kick address. Any other value written to either kick address closes the gate again; writing zero is the usual way to do this. Writes to the kick addresses always reach the gate's own sequencer, so software can change the lock state at any time.

The bus side is a plain single-cycle write strobe with address and data. There is no back-pressure: every write is dealt with in the cycle it is presented, and the gate never stalls the bus. For each strobe the gate produces a write enable for the protected file in the same cycle. It also drives a lock flag, which is high whenever protected writes are refused. Reads do not pass through the gate, so they are never blocked. The number of keys, the key values, the kick base address and the bus widths are all parameters. Kick register `i` sits at the base address plus `4*i`, and the keys must be written in ascending index order.

Top module: `kick_write_gate`

## Requirements
- R1: While reset is asserted, and after it is released, `locked` is 1 and `prot_we` is 0.
- R2: With the default parameters, kick 0 is address 0x6C and takes key 0x83E70B13. Kick 1 is address 0x70 and takes key 0x95A4F1E0. Writing key 0 to kick 0 and then key 1 to kick 1 opens the gate, and `locked` reads 0 from the clock edge that takes the second write.
- R3: While `locked` is 1, a strobed write to any address that is not a kick address gives `prot_we` = 0.
- R4: While `locked` is 0, `prot_we` equals `bus_we` in the same cycle for any address that is not a kick address.
- R5: A write to a kick address never asserts `prot_we`, whatever the data and the lock state.
- R6: Writing any value other than its own key to a kick address closes the gate and clears any partial progress. After that, key 1 written alone does not open the gate.
- R7: The order of the keys matters. Key 1 written before key 0 leaves the gate locked, and only a later key 1 write opens it.
- R8: From the open state, writing zero to a kick address closes the gate at the next clock edge.
- R9: Writes to addresses that are not kick addresses, between the key 0 write and the key 1 write, do not disturb the partial progress.
- R10: Writing key 0 to kick 0 while the gate is open closes it back to the partial state. A key 1 write then reopens it.
- R11: A cycle with `bus_we` = 0 changes nothing, even when the kick address and a key are on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the bus write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| prot_we | output | 1 | Write enable forwarded to the protected register file |
| locked | output | 1 | High while protected writes are refused |

## Verification
The bench builds the gate with its default parameters. These are an 8-bit address, 32-bit data, two keys and a kick base of 0x6C. An 8-bit address space is small enough that random addresses land on the kick registers often, and still leaves many protected addresses around them. Random traffic is biased toward the two kick addresses, and about half of the kick writes carry the correct key. This produces every transition of the unlock progress, including out-of-order keys, a rewrite while open, and protected writes in each state.

// File: rtl/kick_gate_pkg.sv
package kick_gate_pkg;

  typedef logic [7:0] prog_t;

  typedef enum logic [1:0] {
    KICK_NONE = 2'd0,
    KICK_GOOD = 2'd1,
    KICK_BAD  = 2'd2
  } kick_ev_e;

  // Progress after one kick event at index idx.
  function automatic prog_t next_progress(prog_t cur, int idx, kick_ev_e ev);
    prog_t res;
    res = cur;
    case (ev)
      KICK_BAD:  res = '0;
      KICK_GOOD: begin
        if (cur == prog_t'(idx))  res = prog_t'(idx + 1);
        else if (idx == 0)        res = prog_t'(1);
      end
      default:   res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/kick_decode.sv
module kick_decode #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_KEYS = 2,
  parameter logic [ADDR_W-1:0] KICK_BASE = 8'h6C,
  parameter logic [NUM_KEYS*DATA_W-1:0] KEYS = {32'h95A4F1E0, 32'h83E70B13}
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                we,
  output logic [NUM_KEYS-1:0] sel,
  output logic [NUM_KEYS-1:0] hit,
  output logic [NUM_KEYS-1:0] good
);

  for (genvar gi = 0; gi < NUM_KEYS; gi++) begin : g_kick
    localparam logic [ADDR_W-1:0] KADDR = ADDR_W'(KICK_BASE + ADDR_W'(4 * gi));
    localparam logic [DATA_W-1:0] KVAL  = KEYS[gi*DATA_W +: DATA_W];
    assign sel[gi]  = (addr == KADDR);
    assign hit[gi]  = sel[gi] & we;
    assign good[gi] = hit[gi] & (wdata == KVAL);
  end

endmodule

// File: rtl/kick_unlock_seq.sv
module kick_unlock_seq
  import kick_gate_pkg::*;
#(
  parameter int NUM_KEYS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KEYS-1:0] hit,
  input  logic [NUM_KEYS-1:0] good,
  output logic                open
);

  localparam prog_t FULL = prog_t'(NUM_KEYS);

  prog_t prog_q, prog_d;

  always_comb begin
    kick_ev_e ev;
    prog_d = prog_q;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (!hit[i])      ev = KICK_NONE;
      else if (good[i]) ev = KICK_GOOD;
      else              ev = KICK_BAD;
      prog_d = next_progress(prog_d, i, ev);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prog_q <= '0;
    else        prog_q <= prog_d;
  end

  assign open = (prog_q == FULL);

endmodule

// File: rtl/kick_write_gate.sv
module kick_write_gate #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_KEYS = 2,
  parameter logic [ADDR_W-1:0] KICK_BASE = 8'h6C,
  parameter logic [NUM_KEYS*DATA_W-1:0] KEYS = {32'h95A4F1E0, 32'h83E70B13}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic              prot_we,
  output logic              locked
);

  logic [NUM_KEYS-1:0] kick_sel, kick_hit, kick_good;
  logic                gate_open;

  kick_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_KEYS(NUM_KEYS),
    .KICK_BASE(KICK_BASE), .KEYS(KEYS)
  ) u_decode (
    .addr (bus_addr),
    .wdata(bus_wdata),
    .we   (bus_we),
    .sel  (kick_sel),
    .hit  (kick_hit),
    .good (kick_good)
  );

  kick_unlock_seq #(.NUM_KEYS(NUM_KEYS)) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .hit  (kick_hit),
    .good (kick_good),
    .open (gate_open)
  );

  assign prot_we = bus_we & gate_open & ~(|kick_sel);
  assign locked  = ~gate_open;

endmodule

// File: rtl/kick_write_gate_chk.sv
module kick_write_gate_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_KEYS = 2,
  parameter logic [ADDR_W-1:0] KICK_BASE = 8'h6C,
  parameter logic [NUM_KEYS*DATA_W-1:0] KEYS = {32'h95A4F1E0, 32'h83E70B13}
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              prot_we,
  input logic              locked
);

  localparam logic [ADDR_W-1:0] LAST_ADDR =
    ADDR_W'(KICK_BASE + ADDR_W'(4 * (NUM_KEYS - 1)));
  localparam logic [DATA_W-1:0] LAST_KEY =
    KEYS[(NUM_KEYS-1)*DATA_W +: DATA_W];

  logic on_kick, bad_kick;
  always_comb begin
    on_kick  = 1'b0;
    bad_kick = 1'b0;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (bus_addr == ADDR_W'(KICK_BASE + ADDR_W'(4 * i))) begin
        on_kick = 1'b1;
        if (bus_wdata != KEYS[i*DATA_W +: DATA_W]) bad_kick = 1'b1;
      end
    end
  end

  p_reset_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> locked);

  p_unlock_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(bus_we) && $past(bus_addr) == LAST_ADDR
                       && $past(bus_wdata) == LAST_KEY));

  p_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !prot_we);

  p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && bus_we && !on_kick) |-> prot_we);

  p_kick_no_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    on_kick |-> !prot_we);

  p_bad_relock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bad_kick) |=> locked);

  p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(locked));

endmodule

bind kick_write_gate kick_write_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_KEYS(NUM_KEYS),
  .KICK_BASE(KICK_BASE), .KEYS(KEYS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .prot_we(prot_we), .locked(locked)
);

// File: tb/kick_write_gate_bench.sv
`timescale 1ns/1ps
module kick_write_gate_bench;

  localparam logic [7:0]  A0 = 8'h6C;
  localparam logic [7:0]  A1 = 8'h70;
  localparam logic [31:0] K0 = 32'h83E70B13;
  localparam logic [31:0] K1 = 32'h95A4F1E0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        prot_we, locked;

  int n_chk = 0;
  int n_fail = 0;
  int prog = 0;
  bit done = 0;

  always #10 clk = ~clk;

  kick_write_gate u_kick_write_gate (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .prot_we(prot_we), .locked(locked)
  );

  function automatic int model_next(int p, logic [7:0] a, logic [31:0] d, logic we);
    if (!we) return p;
    if (a == A0) return (d == K0) ? 1 : 0;
    if (a == A1) begin
      if (d != K1) return 0;
      return (p == 1) ? 2 : p;
    end
    return p;
  endfunction

  function automatic logic exp_prot(int p, logic [7:0] a, logic we);
    return we && (a != A0) && (a != A1) && (p == 2);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic op(input logic [7:0] a, input logic [31:0] d, input logic we,
                    input string tag);
    logic ep;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = we;
    #5;
    ep = exp_prot(prog, a, we);
    chk(prot_we === ep, tag, "prot_we", longint'(prot_we), longint'(ep));
    @(posedge clk);
    #1;
    prog = model_next(prog, a, d, we);
    chk(locked === (prog != 2), tag, "locked", longint'(locked), longint'(prog != 2));
  endtask

  task automatic unlock(input string tag);
    op(A0, K0, 1'b1, tag);
    op(A1, K1, 1'b1, tag);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      summary();
    end
  end

  initial begin
    logic [7:0] ra;
    logic [31:0] rd;
    logic rw;
    int sel;
    void'($urandom(32'd4242));

    // R1: reset state, even with a write presented
    bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 32'hFFFF_FFFF;
    #35;
    chk(locked === 1'b1, "R1", "locked in reset", longint'(locked), 1);
    chk(prot_we === 1'b0, "R1", "prot_we in reset", longint'(prot_we), 0);
    @(negedge clk); bus_we = 1'b0; rst_n = 1'b1;
    @(posedge clk); #1;
    chk(locked === 1'b1, "R1", "locked after reset", longint'(locked), 1);

    op(8'h10, 32'h1, 1'b1, "R3");          // R3: locked blocks
    op(8'h00, 32'h2, 1'b1, "R3");
    unlock("R2");                          // R2: opens
    op(8'h10, 32'h3, 1'b1, "R4");          // R4: passes
    op(8'h10, 32'h3, 1'b0, "R4");
    op(A0, 32'h0, 1'b0, "R11");            // R11: no strobe, no change
    op(A1, K1, 1'b1, "R5");                // R5: kick write while open
    op(A1, 32'h0, 1'b1, "R8");             // R8: zero relocks
    op(8'h20, 32'h4, 1'b1, "R8");
    op(A0, K0, 1'b1, "R6");
    op(A0, 32'h1234, 1'b1, "R6");          // R6: wrong value clears progress
    op(A1, K1, 1'b1, "R6");
    op(A1, K1, 1'b1, "R7");                // R7: reverse order
    op(A0, K0, 1'b1, "R7");
    op(A1, K1, 1'b1, "R7");
    op(A0, K0, 1'b1, "R10");               // R10: key 0 while open
    op(8'h30, 32'h5, 1'b1, "R10");
    op(A1, K1, 1'b1, "R10");
    op(A0, 32'h0, 1'b1, "R9");
    op(A0, K0, 1'b1, "R9");                // R9: other writes between keys
    op(8'h44, 32'h6, 1'b1, "R9");
    op(8'h71, K1, 1'b1, "R9");
    op(A1, K1, 1'b1, "R9");
    op(8'h44, 32'h7, 1'b1, "R9");
    op(A0, K0, 1'b0, "R11");
    op(A1, 32'h0, 1'b0, "R11");

    for (int n = 0; n < 1500; n++) begin
      sel = $urandom_range(0, 99);
      if (sel < 25)      ra = A0;
      else if (sel < 50) ra = A1;
      else               ra = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 1) == 0) rd = (ra == A1) ? K1 : K0;
      else                           rd = $urandom;
      rw = ($urandom_range(0, 9) < 8);
      op(ra, rd, rw, "R5");
    end

    done = 1;
    summary();
  end

endmodule